// File: doc/BRIEF.md
# Diminished-One Modulo 65537 Adder and Negater

This unit does addition and negation in the ring of integers modulo 65537. It is the arithmetic core that a decimation-in-frequency butterfly needs. Operands are 17-bit words in diminished-one code. A nonzero value v is stored as v-1 in the low 16 bits, with bit 16 clear. The value zero has its own word, in which only bit 16 is set.

The unit takes two coded operands. It returns their coded modular sum and the coded modular negation of the first operand. When both addends are nonzero, the sum is formed by a 16-bit addition followed by an end-around correction: the inverted carry-out is added back in. The carry-out of that correction becomes the zero flag.

A build parameter places an output register with a clock enable after the arithmetic, so the unit can sit between pipeline registers. With the parameter cleared, the outputs are purely combinational.

Top module: `dm1_addneg`

## Requirements
- R1: A value v in 1..65536 is coded as v-1 in bits 15..0 with bit 16 at 0. The value 0 is coded as 0x10000 (bit 16 at 1, bits 15..0 at 0). Both inputs and both outputs use this code.
- R2: When operand A is the zero word, the sum equals operand B bit for bit.
- R3: When operand B is the zero word and A is nonzero, the sum equals operand A bit for bit.
- R4: When both operands are nonzero, the sum is the code of (value(A)+value(B)) mod 65537.
- R5: A sum of two nonzero operands whose values total exactly 65537 gives the zero word 0x10000.
- R6: The negation of a nonzero A has bits 15..0 equal to the inverse of A's bits 15..0 and bit 16 at 0, which is the code of 65537-value(A).
- R7: The negation of the zero word is the zero word.
- R8: No output ever has bit 16 set while any of bits 15..0 is set.
- R9: With the output register present (default), a result appears on the outputs one clock after the inputs are sampled with the enable high. While the enable is low, both outputs hold their values.
- R10: A synchronous active-high reset loads the zero word 0x10000 into both registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the output register |
| a_in | input | 17 | Operand A, diminished-one code |
| b_in | input | 17 | Operand B, diminished-one code |
| sum_out | output | 17 | Coded sum A+B modulo 65537 |
| neg_out | output | 17 | Coded negation of A modulo 65537 |

## Verification
The hardest case to reach is the pair of nonzero addends whose correction addition carries out into bit 16, because their values must total exactly 65537. Uniform random operands almost never produce such a pair. The stimulus therefore builds these pairs on purpose: it picks a random value v and drives v together with 65537-v, alongside the end points 1 and 65536. A separate set of cases drives enable-low cycles with changing inputs, to show that the registered outputs hold.

// File: rtl/dm1_pkg.sv
package dm1_pkg;
    localparam int DATA_W = 16;
    localparam int WORD_W = DATA_W + 1;

    typedef logic [WORD_W-1:0] dm_word_t;

    localparam dm_word_t ZERO_CODE = dm_word_t'(1) << DATA_W;

    typedef struct packed {
        dm_word_t sum;
        dm_word_t neg;
    } dm_pair_t;

    function automatic logic is_zero_code(input dm_word_t w);
        return w[DATA_W];
    endfunction

    function automatic logic is_canonical(input dm_word_t w);
        return !(w[DATA_W] && (|w[DATA_W-1:0]));
    endfunction
endpackage

// File: rtl/dm1_adder.sv
module dm1_adder
    import dm1_pkg::*;
(
    input  dm_word_t op_a,
    input  dm_word_t op_b,
    output dm_word_t sum
);
    logic [DATA_W:0] first_add;
    logic            carry_bar;
    logic [DATA_W:0] fix_add;

    always_comb begin
        first_add = {1'b0, op_a[DATA_W-1:0]} + {1'b0, op_b[DATA_W-1:0]};
        carry_bar = ~first_add[DATA_W];
        fix_add   = {1'b0, first_add[DATA_W-1:0]} + {{DATA_W{1'b0}}, carry_bar};
        if (is_zero_code(op_a))
            sum = op_b;
        else if (is_zero_code(op_b))
            sum = op_a;
        else
            sum = {fix_add[DATA_W], fix_add[DATA_W-1:0]};
    end
endmodule

// File: rtl/dm1_negater.sv
module dm1_negater
    import dm1_pkg::*;
(
    input  dm_word_t op_a,
    output dm_word_t neg
);
    always_comb begin
        if (is_zero_code(op_a))
            neg = op_a;
        else
            neg = {1'b0, ~op_a[DATA_W-1:0]};
    end
endmodule

// File: rtl/dm1_stage.sv
module dm1_stage
    import dm1_pkg::*;
#(
    parameter bit PIPE_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  dm_pair_t d,
    output dm_pair_t q
);
    generate
        if (PIPE_REG) begin : g_reg
            dm_pair_t q_r;
            always_ff @(posedge clk) begin
                if (rst)
                    q_r <= '{sum: ZERO_CODE, neg: ZERO_CODE};
                else if (en)
                    q_r <= d;
            end
            assign q = q_r;

            assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !en |=> $stable(q));
            assert_reset_R10: assert property (@(posedge clk)
                rst |=> (q.sum == ZERO_CODE && q.neg == ZERO_CODE));
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/dm1_addneg.sv
module dm1_addneg
    import dm1_pkg::*;
#(
    parameter bit PIPE_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [WORD_W-1:0]   a_in,
    input  logic [WORD_W-1:0]   b_in,
    output logic [WORD_W-1:0]   sum_out,
    output logic [WORD_W-1:0]   neg_out
);
    dm_pair_t comb_res;
    dm_pair_t reg_res;

    dm1_adder i_adder (
        .op_a (a_in),
        .op_b (b_in),
        .sum  (comb_res.sum)
    );

    dm1_negater i_negater (
        .op_a (a_in),
        .neg  (comb_res.neg)
    );

    dm1_stage #(.PIPE_REG(PIPE_REG)) i_stage (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (comb_res),
        .q   (reg_res)
    );

    assign sum_out = reg_res.sum;
    assign neg_out = reg_res.neg;

    generate
        if (PIPE_REG) begin : g_chk
            assert_sum_canonical_R8: assert property (@(posedge clk) disable iff (rst)
                is_canonical(sum_out));
            assert_neg_canonical_R8: assert property (@(posedge clk) disable iff (rst)
                is_canonical(neg_out));
            assert_a_zero_pass_R2: assert property (@(posedge clk) disable iff (rst)
                (en && is_zero_code(a_in)) |=> (sum_out == $past(b_in)));
            assert_neg_zero_R7: assert property (@(posedge clk) disable iff (rst)
                (en && a_in == ZERO_CODE) |=> (neg_out == ZERO_CODE));
            assert_neg_flag_R6: assert property (@(posedge clk) disable iff (rst)
                (en && !is_zero_code(a_in)) |=> !neg_out[DATA_W]);
        end
    endgenerate
endmodule

// File: tb/test_dm1_addneg.sv
module test_dm1_addneg;
    localparam int MOD = 65537;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [16:0] a_in = 17'h10000;
    logic [16:0] b_in = 17'h10000;
    logic [16:0] sum_out;
    logic [16:0] neg_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [16:0] sum;
        logic [16:0] neg;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [16:0] last_sum = 17'h10000;
    logic [16:0] last_neg = 17'h10000;

    always #10 clk = ~clk;

    dm1_addneg i_dm1_addneg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .a_in    (a_in),
        .b_in    (b_in),
        .sum_out (sum_out),
        .neg_out (neg_out)
    );

    function automatic logic [16:0] enc(input int v);
        return (v == 0) ? 17'h10000 : 17'(v - 1);
    endfunction

    function automatic int dec(input logic [16:0] w);
        return w[16] ? 0 : int'(w[15:0]) + 1;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int va, input int vb, input string tag);
        exp_t e;
        @(negedge clk);
        a_in = enc(va);
        b_in = enc(vb);
        en   = 1'b1;
        e.sum = enc((va + vb) % MOD);
        e.neg = enc((MOD - va) % MOD);
        e.tag = tag;
        last_sum = e.sum;
        last_neg = e.neg;
        sb_q.push_back(e);
    endtask

    task automatic drive_idle(input int va, input int vb);
        exp_t e;
        @(negedge clk);
        a_in = enc(va);
        b_in = enc(vb);
        en   = 1'b0;
        e.sum = last_sum;
        e.neg = last_neg;
        e.tag = "R9";
        sb_q.push_back(e);
    endtask

    // Monitor: result of a negedge drive is visible after the next rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " sum"}, sum_out, e.sum);
            check({e.tag, " neg"}, neg_out, e.neg);
            checks++;
            if ((sum_out[16] && |sum_out[15:0]) || (neg_out[16] && |neg_out[15:0])) begin
                errors++;
                $display("FAIL R8: actual sum %h neg %h expected canonical words", sum_out, neg_out);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 sum", sum_out, 17'h10000);
        check("R10 neg", neg_out, 17'h10000);

        // R1 R2 R3 R7: zero operands
        drive(0, 0, "R2");
        drive(0, 1, "R2");
        drive(0, 65536, "R2");
        drive(0, 40000, "R2");
        drive(1, 0, "R3");
        drive(65535, 0, "R3");
        drive(65536, 0, "R3");
        drive(0, 12345, "R7");
        // R4 R6 boundary operands
        drive(1, 1, "R4");
        drive(65535, 65535, "R4");
        drive(65536, 65536, "R4");
        drive(65535, 1, "R4");
        drive(65536, 2, "R4");
        drive(1, 7, "R6");
        drive(65536, 9, "R6");
        drive(65535, 3, "R6");
        // R5: values totalling the modulus
        drive(1, 65536, "R5");
        drive(65536, 1, "R5");
        drive(2, 65535, "R5");
        for (int i = 0; i < 40; i++) begin
            int v;
            v = 1 + ($urandom % 65536);
            drive(v, MOD - v, "R5");
        end
        // R9: enable low holds outputs
        drive(1234, 5678, "R9");
        drive_idle(0, 99);
        drive_idle(777, 65536);
        drive_idle(65535, 65535);
        drive(42, 0, "R9");
        // R1 R4 R6: random operands, with some zeros mixed in
        for (int i = 0; i < 400; i++) begin
            int va, vb;
            va = $urandom % MOD;
            vb = $urandom % MOD;
            if (i % 9 == 0) va = 0;
            if (i % 11 == 0) vb = 0;
            drive(va, vb, "R4");
            if (i % 37 == 0) drive_idle($urandom % MOD, $urandom % MOD);
        end
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule